// File: doc/BRIEF.md
# SPI Transmit FIFO Engine

This block is the transmit half of a register-mapped SPI master. Software enables the engine and picks a bit rate through a control register, then writes bytes into a data register. Each accepted byte lands in a 16-entry byte FIFO. A shift sequencer takes bytes from the FIFO head and drives them onto one serial output line, most significant bit first, holding each bit for a programmable number of system clocks. A one-cycle `bit_start` strobe marks the first cycle of every bit so that a downstream serial-clock generator or a monitor can frame the data.

A status register reports how many bytes remained after the most recently finished byte, holds a software-set threshold and an interrupt enable, and carries a sticky flag. The flag is raised whenever a byte completes and the remaining count is below the threshold. It drives a level interrupt request. Software uses the threshold to be told that the FIFO has room to refill.

The sequencer has three states. `ST_IDLE` waits for data; it moves to `ST_SHIFT` (the load transition) when the engine may run and the FIFO holds a byte. `ST_SHIFT` counts one bit period per bit. At the end of a bit that is not the last one it either shifts and stays (shift transition) or, if the engine was halted, moves to `ST_PAUSE` (hold transition). At the end of the last bit it retires the byte and either loads the next byte and stays in `ST_SHIFT` (chain transition) or returns to `ST_IDLE` (drain transition). `ST_PAUSE` returns to `ST_SHIFT` with the next bit once the engine may run again (resume transition).

Top module: `spi_tx_fifo_engine`

## Requirements
- R1: After reset every register reads zero (address 0 control, address 1 status, address 2 data; address 2 and 3 always read zero), `sdo` is low and `irq` is low.
- R2: A write to address 2 while the engine is enabled (control bit 15) stores the low byte; bytes leave on `sdo` in write order, most significant bit first, and `bit_start` is high for exactly the first cycle of each bit.
- R3: Control bits 2:0 hold a code n; each bit lasts 2 << n system clocks, and consecutive bits and consecutive bytes follow each other with no gap.
- R4: With the enable clear or code 7 selected, no new bit starts: a bit in progress runs to its end and the sequencer holds; once allowed again the same byte continues with its next bit.
- R5: The FIFO holds 16 bytes, counting the byte being shifted; a data write while 16 are held is dropped and leaves the contents unchanged.
- R6: A data write while the enable is clear is dropped.
- R7: A new rate code takes effect at the next bit boundary; the bit in progress keeps its original length.
- R8: When a byte finishes, status bits 3:0 take the number of bytes still held; they do not change at other times.
- R9: When a byte finishes and the held count is below the threshold in status bits 7:4, status bit 15 is set and stays set until software clears it.
- R10: Software can write only status bit 14 (interrupt enable) and bits 7:4 (threshold); writing 1 to bit 15 clears the flag, and a flag-setting event in the same cycle wins.
- R11: `irq` is high exactly while status bit 15 and status bit 14 are both set.
- R12: Shifting stops when the held count reaches zero, and a new data write restarts it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` (combinational) |
| sdo | output | 1 | Serial data out, MSB first |
| bit_start | output | 1 | High in the first cycle of each transmitted bit |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its default parameters: a 4-bit FIFO address (16 entries), 8-bit bytes and a 3-bit rate code. The 16-entry depth keeps the overflow case within a few thousand cycles even at the slowest code, and the 3-bit code reaches both the reserved halting value 7 and a range of periods from 2 to 128 clocks, so rate changes in mid-byte, pauses at a bit boundary and threshold crossings at every FIFO level can all be driven directly and mixed with random byte streams at random rates.

// File: rtl/spi_tx_pkg.sv
package spi_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_PAUSE = 2'd2
    } shift_state_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    localparam int REG_W      = 16;
    localparam int CTRL_EN    = 15;
    localparam int STAT_FLAG  = 15;
    localparam int STAT_IE    = 14;
    localparam int STAT_THR_L = 4;
    localparam int FLD_W      = 4;

endpackage

// File: rtl/spi_tx_regs.sv
module spi_tx_regs
    import spi_tx_pkg::*;
#(
    parameter int DIV_W = 3,
    parameter int AW    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [1:0]           reg_addr,
    input  logic [REG_W-1:0]     reg_wdata,
    input  logic                 byte_done,
    input  logic [AW:0]          level_nxt,
    output logic                 enable,
    output logic [DIV_W-1:0]     div_code,
    output logic                 push_req,
    output logic [REG_W-1:0]     reg_rdata,
    output logic                 irq
);

    localparam int LVL_W = AW + 1;

    logic               en_q;
    logic [DIV_W-1:0]   code_q;
    logic               ie_q;
    logic               flag_q;
    logic [FLD_W-1:0]   thr_q;
    logic [FLD_W-1:0]   snap_q;

    logic wr_ctrl, wr_stat, wr_data, below_thr, flag_clr;

    assign wr_ctrl   = reg_wr && (reg_addr == ADDR_CTRL);
    assign wr_stat   = reg_wr && (reg_addr == ADDR_STAT);
    assign wr_data   = reg_wr && (reg_addr == ADDR_DATA);
    assign below_thr = byte_done && (level_nxt < LVL_W'(thr_q));
    assign flag_clr  = wr_stat && reg_wdata[STAT_FLAG];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            code_q <= '0;
        end else if (wr_ctrl) begin
            en_q   <= reg_wdata[CTRL_EN];
            code_q <= reg_wdata[DIV_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q   <= 1'b0;
            thr_q  <= '0;
            flag_q <= 1'b0;
            snap_q <= '0;
        end else begin
            if (wr_stat) begin
                ie_q  <= reg_wdata[STAT_IE];
                thr_q <= reg_wdata[STAT_THR_L +: FLD_W];
            end
            if (below_thr)
                flag_q <= 1'b1;
            else if (flag_clr)
                flag_q <= 1'b0;
            if (byte_done)
                snap_q <= level_nxt[FLD_W-1:0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[CTRL_EN]     = en_q;
                reg_rdata[DIV_W-1:0]   = code_q;
            end
            ADDR_STAT: begin
                reg_rdata[STAT_FLAG]            = flag_q;
                reg_rdata[STAT_IE]              = ie_q;
                reg_rdata[STAT_THR_L +: FLD_W]  = thr_q;
                reg_rdata[FLD_W-1:0]            = snap_q;
            end
            default: reg_rdata = '0;
        endcase
    end

    assign enable   = en_q;
    assign div_code = code_q;
    assign push_req = wr_data && en_q;
    assign irq      = flag_q && ie_q;

    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q && !flag_clr |=> flag_q);

    a_r10_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr && !byte_done |=> !flag_q);

    a_r8_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_done && !wr_stat |=> $stable(snap_q));

endmodule

// File: rtl/spi_tx_fifo.sv
module spi_tx_fifo #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    input  logic          retire,
    output logic [DW-1:0] head,
    output logic [AW:0]   level,
    output logic [AW:0]   level_nxt
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [AW:0]   lvl_q;
    logic          full, accept;

    assign full   = (lvl_q == (AW+1)'(DEPTH));
    assign accept = push && !full;

    always_comb begin
        level_nxt = lvl_q;
        if (accept && !retire)
            level_nxt = lvl_q + 1'b1;
        else if (!accept && retire)
            level_nxt = lvl_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (accept)
            mem[wptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            lvl_q <= '0;
        end else begin
            if (accept) wptr <= wptr + 1'b1;
            if (pop)    rptr <= rptr + 1'b1;
            lvl_q <= level_nxt;
        end
    end

    assign head  = mem[rptr];
    assign level = lvl_q;

    a_r5_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_q <= (AW+1)'(DEPTH));

    a_r5_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        push && full && !retire |=> lvl_q == (AW+1)'(DEPTH));

    a_r2_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> lvl_q != '0);

endmodule

// File: rtl/spi_tx_divider.sv
module spi_tx_divider #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] code,
    output logic             bit_last
);

    localparam int MAXP   = 2 << ((1 << DIV_W) - 2);
    localparam int CW     = $clog2(MAXP);
    localparam int SPAN_W = CW + 1;

    logic [SPAN_W-1:0] span;
    logic [CW-1:0]     cnt_q, last_q;

    assign span = SPAN_W'(2) << code;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            last_q <= '0;
        end else if (restart) begin
            cnt_q  <= '0;
            last_q <= CW'(span - SPAN_W'(1));
        end else if (run) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign bit_last = run && (cnt_q == last_q);

    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> cnt_q <= last_q);

    a_r7_period_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> $stable(last_q));

endmodule

// File: rtl/spi_tx_shifter.sv
module spi_tx_shifter
    import spi_tx_pkg::*;
#(
    parameter int DW    = 8,
    parameter int AW    = 4,
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [DIV_W-1:0] div_code,
    input  logic [AW:0]      level,
    input  logic [DW-1:0]    head,
    input  logic             bit_last,
    output logic             pop,
    output logic             retire,
    output logic             restart,
    output logic             run,
    output logic             sdo,
    output logic             bit_start
);

    localparam int IDX_W = $clog2(DW);

    shift_state_e state, nxt;
    logic [DW-1:0]    shreg;
    logic [IDX_W-1:0] bit_idx;
    logic             first_q;
    logic             run_ok, do_load, do_shift;

    assign run_ok = enable && (div_code != {DIV_W{1'b1}});

    always_comb begin
        nxt      = state;
        do_load  = 1'b0;
        do_shift = 1'b0;
        retire   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (run_ok && level != '0) begin
                    do_load = 1'b1;
                    nxt     = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (bit_last) begin
                    if (bit_idx == '0) begin
                        retire = 1'b1;
                        if (run_ok && level > (AW+1)'(1))
                            do_load = 1'b1;
                        else
                            nxt = ST_IDLE;
                    end else if (run_ok) begin
                        do_shift = 1'b1;
                    end else begin
                        nxt = ST_PAUSE;
                    end
                end
            end
            ST_PAUSE: begin
                if (run_ok) begin
                    do_shift = 1'b1;
                    nxt      = ST_SHIFT;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_idx <= '0;
            first_q <= 1'b0;
        end else begin
            first_q <= do_load || do_shift;
            if (do_load) begin
                shreg   <= head;
                bit_idx <= IDX_W'(DW - 1);
            end else if (do_shift) begin
                shreg   <= {shreg[DW-2:0], 1'b0};
                bit_idx <= bit_idx - 1'b1;
            end
        end
    end

    always_comb begin
        pop       = do_load;
        restart   = do_load || do_shift;
        run       = (state == ST_SHIFT);
        bit_start = (state == ST_SHIFT) && first_q;
        sdo       = (state == ST_IDLE) ? 1'b0 : shreg[DW-1];
    end

    a_r12_drain_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_SHIFT && bit_last && bit_idx == '0 && level == (AW+1)'(1)
        |=> state == ST_IDLE);

    a_r4_no_start_halted: assert property (@(posedge clk) disable iff (!rst_n)
        !run_ok |=> !first_q);

    a_r4_pause_holds: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_PAUSE && !run_ok |=> state == ST_PAUSE && $stable(shreg));

endmodule

// File: rtl/spi_tx_fifo_engine.sv
module spi_tx_fifo_engine
    import spi_tx_pkg::*;
#(
    parameter int AW    = 4,
    parameter int DW    = 8,
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [15:0]      reg_wdata,
    output logic [15:0]      reg_rdata,
    output logic             sdo,
    output logic             bit_start,
    output logic             irq
);

    logic             enable, push_req, pop, retire, restart, run, bit_last;
    logic [DIV_W-1:0] div_code;
    logic [AW:0]      level, level_nxt;
    logic [DW-1:0]    head;

    spi_tx_regs #(.DIV_W(DIV_W), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .byte_done (retire),
        .level_nxt (level_nxt),
        .enable    (enable),
        .div_code  (div_code),
        .push_req  (push_req),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    spi_tx_fifo #(.AW(AW), .DW(DW)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push_req),
        .wdata     (reg_wdata[DW-1:0]),
        .pop       (pop),
        .retire    (retire),
        .head      (head),
        .level     (level),
        .level_nxt (level_nxt)
    );

    spi_tx_divider #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .run      (run),
        .code     (div_code),
        .bit_last (bit_last)
    );

    spi_tx_shifter #(.DW(DW), .AW(AW), .DIV_W(DIV_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .div_code  (div_code),
        .level     (level),
        .head      (head),
        .bit_last  (bit_last),
        .pop       (pop),
        .retire    (retire),
        .restart   (restart),
        .run       (run),
        .sdo       (sdo),
        .bit_start (bit_start)
    );

    a_r11_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> reg_wr || 1'b1 ? (u_regs.ie_q && u_regs.flag_q) : 1'b0);

endmodule

// File: tb/tb_spi_tx_fifo_engine.sv
`timescale 1ns/1ps
module tb_spi_tx_fifo_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        sdo, bit_start, irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done_flag = 0;

    logic [7:0] rxq[$];
    int         starts[$];
    logic [7:0] cur = 8'h00;
    int         nbits = 0;

    spi_tx_fifo_engine dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sdo(sdo),
        .bit_start(bit_start), .irq(irq)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && bit_start) begin
            starts.push_back(cyc);
            cur = {cur[6:0], sdo};
            nbits = nbits + 1;
            if (nbits == 8) begin
                rxq.push_back(cur);
                nbits = 0;
            end
        end
    end

    function automatic int period_of(input int code);
        return 2 << code;
    endfunction

    function automatic logic [15:0] stat_word(input bit flag, input bit ie,
                                             input int thr, input int cnt);
        logic [15:0] w;
        w = 16'h0;
        w[15] = flag;
        w[14] = ie;
        w[7:4] = thr[3:0];
        w[3:0] = cnt[3:0];
        return w;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic clr();
        rxq.delete();
        starts.delete();
        nbits = 0;
    endtask

    task automatic wait_bytes(input int n, input int lim);
        int k = 0;
        while (rxq.size() < n && k < lim) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic wait_starts(input int n, input int lim);
        int k = 0;
        while (starts.size() < n && k < lim) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #800000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  exp_q[$];
        void'($urandom(32'h5EED_1234));

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, v); check(v == 16'h0, "R1", "ctrl after reset", v, 0);
        rd(2'd1, v); check(v == 16'h0, "R1", "status after reset", v, 0);
        rd(2'd2, v); check(v == 16'h0, "R1", "data read", v, 0);
        check(sdo == 1'b0, "R1", "sdo after reset", sdo, 0);
        check(irq == 1'b0, "R1", "irq after reset", irq, 0);

        // R2 / R3 / R8 / R12 basic stream at period 2
        clr();
        wr(2'd0, 16'h8000);
        wr(2'd2, 16'h00A5);
        wr(2'd2, 16'h003C);
        wait_bytes(2, 2000);
        idle(30);
        check(rxq.size() == 2, "R2", "byte count", rxq.size(), 2);
        if (rxq.size() == 2) begin
            check(rxq[0] == 8'hA5, "R2", "first byte", rxq[0], 8'hA5);
            check(rxq[1] == 8'h3C, "R2", "second byte", rxq[1], 8'h3C);
        end
        begin
            bit gap_ok = 1;
            for (int i = 1; i < starts.size(); i++)
                if (starts[i] - starts[i-1] != period_of(0)) gap_ok = 0;
            check(gap_ok && starts.size() == 16, "R3", "back-to-back gaps of 2", starts.size(), 16);
        end
        rd(2'd1, v); check(v == 16'h0000, "R8", "status after drain", v, 0);
        check(starts.size() == 16, "R12", "no bits after drain", starts.size(), 16);
        wr(2'd2, 16'h0081);
        wait_bytes(3, 2000);
        check(rxq.size() == 3 && rxq[2] == 8'h81, "R12", "restart on write", rxq.size(), 3);

        // R2 / R3 random streams
        for (int r = 0; r < 6; r++) begin
            int code = $urandom_range(0, 3);
            int n = $urandom_range(1, 6);
            clr();
            exp_q.delete();
            wr(2'd0, 16'h8000 | 16'(code));
            for (int i = 0; i < n; i++) begin
                logic [7:0] b = 8'($urandom);
                exp_q.push_back(b);
                wr(2'd2, {8'h00, b});
            end
            wait_bytes(n, 20000);
            check(rxq.size() == n, "R2", "random byte count", rxq.size(), n);
            for (int i = 0; i < n && i < rxq.size(); i++)
                check(rxq[i] == exp_q[i], "R2", "random byte value", rxq[i], exp_q[i]);
            if (starts.size() > 1)
                check(starts[1] - starts[0] == period_of(code), "R3", "random bit period",
                      starts[1] - starts[0], period_of(code));
        end

        // R5 overflow at slow rate, R8 mid-stream snapshot
        clr();
        exp_q.delete();
        wr(2'd0, 16'h8006);
        for (int i = 0; i < 17; i++) wr(2'd2, 16'(8'h10 + i));
        wait_bytes(2, 5000);
        rd(2'd1, v); check(v[3:0] == 4'd15, "R8", "snapshot after first byte", v[3:0], 15);
        wait_bytes(17, 20000);
        idle(2000);
        check(rxq.size() == 16, "R5", "bytes sent after overflow", rxq.size(), 16);
        begin
            bit ok = 1;
            for (int i = 0; i < rxq.size(); i++) if (rxq[i] != 8'(8'h10 + i)) ok = 0;
            check(ok, "R5", "FIFO contents kept", rxq.size(), 16);
        end
        rd(2'd1, v); check(v[3:0] == 4'd0, "R8", "snapshot after drain", v[3:0], 0);

        // R9 / R11 threshold flag and irq
        clr();
        wr(2'd0, 16'h8000);
        wr(2'd1, 16'h4020);
        wr(2'd2, 16'h0001); wr(2'd2, 16'h0002); wr(2'd2, 16'h0003);
        wait_bytes(3, 2000);
        idle(10);
        rd(2'd1, v); check(v == stat_word(1, 1, 2, 0), "R9", "flag set below threshold", v, stat_word(1, 1, 2, 0));
        check(irq == 1'b1, "R11", "irq with flag and enable", irq, 1);
        wr(2'd1, 16'h4020);
        rd(2'd1, v); check(v[15] == 1'b1, "R9", "flag sticky", v[15], 1);
        wr(2'd1, 16'hC020);
        rd(2'd1, v); check(v == stat_word(0, 1, 2, 0), "R10", "write 1 clears flag", v, stat_word(0, 1, 2, 0));
        check(irq == 1'b0, "R11", "irq after clear", irq, 0);
        wr(2'd1, 16'h0020);
        wr(2'd2, 16'h0044);
        wait_bytes(4, 2000);
        idle(10);
        rd(2'd1, v); check(v == stat_word(1, 0, 2, 0), "R9", "flag with ie clear", v, stat_word(1, 0, 2, 0));
        check(irq == 1'b0, "R11", "irq masked by enable", irq, 0);
        wr(2'd1, 16'h8000);
        wr(2'd2, 16'h0055);
        wait_bytes(5, 2000);
        idle(10);
        rd(2'd1, v); check(v == 16'h0000, "R9", "no flag at threshold 0", v, 0);

        // R10 writable mask
        wr(2'd1, 16'hFFFF);
        rd(2'd1, v); check(v == stat_word(0, 1, 15, 0), "R10", "writable bits only", v, stat_word(0, 1, 15, 0));
        wr(2'd1, 16'h0000);
        rd(2'd1, v); check(v == 16'h0000, "R10", "status cleared", v, 0);

        // R4 reserved code halts
        clr();
        wr(2'd0, 16'h8007);
        wr(2'd2, 16'h0011); wr(2'd2, 16'h0022);
        idle(300);
        check(starts.size() == 0, "R4", "code 7 no bits", starts.size(), 0);
        wr(2'd0, 16'h8001);
        wait_bytes(2, 2000);
        check(rxq.size() == 2 && rxq[0] == 8'h11 && rxq[1] == 8'h22, "R4", "resume after code 7",
              rxq.size() > 0 ? rxq[0] : 0, 8'h11);

        // R4 pause mid-byte
        clr();
        wr(2'd0, 16'h8001);
        wr(2'd2, 16'h003C);
        wait_starts(3, 2000);
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h0001;
        @(negedge clk); reg_wr = 1'b0;
        idle(60);
        check(starts.size() == 3, "R4", "held at bit boundary", starts.size(), 3);
        wr(2'd0, 16'h8001);
        wait_bytes(1, 2000);
        check(rxq.size() == 1 && rxq[0] == 8'h3C, "R4", "byte intact after pause",
              rxq.size() > 0 ? rxq[0] : 0, 8'h3C);
        check(starts[1] - starts[0] == 4, "R3", "period 4", starts[1] - starts[0], 4);

        // R6 write while disabled
        clr();
        wr(2'd0, 16'h0000);
        wr(2'd2, 16'h0077);
        wr(2'd0, 16'h8000);
        idle(200);
        check(starts.size() == 0 && rxq.size() == 0, "R6", "disabled write dropped", starts.size(), 0);

        // R7 rate change mid-byte
        clr();
        wr(2'd0, 16'h8002);
        wr(2'd2, 16'h00F0);
        wait_starts(3, 2000);
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h8000;
        @(negedge clk); reg_wr = 1'b0;
        wait_bytes(1, 2000);
        check(rxq.size() == 1 && rxq[0] == 8'hF0, "R7", "byte after rate change",
              rxq.size() > 0 ? rxq[0] : 0, 8'hF0);
        if (starts.size() >= 5) begin
            check(starts[3] - starts[2] == 8, "R7", "bit in progress keeps length", starts[3] - starts[2], 8);
            check(starts[4] - starts[3] == 2, "R7", "new period at boundary", starts[4] - starts[3], 2);
        end else begin
            check(0, "R7", "bit starts seen", starts.size(), 5);
        end

        finish_run();
    end

endmodule